// File: doc/BRIEF.md
# ADC Result Register Bus Bridge

This block places four A/D result words and one control byte on an 8-bit processor bus. Each result is a 10-bit sample stored left-aligned in a 16-bit word. The bus reaches every word through two byte addresses. Reading the upper byte returns it at once and, on the same clock edge, copies the lower byte of that word into one shared 8-bit holding latch. A later read of any lower-byte address returns the holding latch and not the live word. Software that reads the upper byte first therefore always gets two halves from the same sample, even if the converter overwrites the word between the two reads.

The control byte holds one writable bit, the external-trigger enable, in bit 7. The other bits always read as 1. A converter-side port writes new results by channel index. An active-low external trigger input passes through a synchronizer, and a falling edge on it becomes a one-cycle start request while the enable is set. The software start input always reaches the start request.

Address map: result channel i has its upper byte at 2*i and its lower byte at 2*i+1, so addresses run 0 to 7. The control byte sits at address 8.

Top module: `adc_rbus_bridge`

## Requirements
- R1: A read of upper-byte address 2*i returns bits 9:2 of the last value written to channel i. All results are 0 after reset.
- R2: A read of an upper-byte address copies that word's lower byte into the holding latch at the same clock edge. The lower byte is {value[1:0], 6'b000000}. A following read of lower-byte address 2*i+1 returns the latch.
- R3: A converter write that lands between an upper-byte read and the next lower-byte read leaves the latch unchanged. The next upper-byte read then shows the new value.
- R4: A lower-byte read returns the latch whatever channel it addresses. The latch is 0x00 after reset and may hold a stale value from another channel.
- R5: The control byte at address 8 reads 0x7F after reset. A bus write sets bit 7 from write data bit 7. Bits 6:0 always read 1 and ignore writes.
- R6: While standby is high, the control byte is forced to 0x7F, so the trigger enable is cleared.
- R7: With the trigger enable at 0, transitions on ext_trig_n never raise start_req.
- R8: With the trigger enable at 1, a falling edge on ext_trig_n raises start_req for exactly one cycle. The pulse starts just after the second rising clock edge at which the input is low. A rising edge on ext_trig_n raises nothing.
- R9: start_req follows sw_start in the same cycle, whatever the trigger enable.
- R10: Reads of addresses 9 to 15 return 0xFF. Bus writes to result addresses 0 to 7 change no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby | input | 1 | Forces the control byte to its reset value |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the access cycle |
| cnv_we | input | 1 | Converter result write strobe |
| cnv_ch | input | 2 | Channel index of the converter write |
| cnv_data | input | 10 | Converter sample |
| ext_trig_n | input | 1 | Asynchronous external trigger, active low |
| sw_start | input | 1 | Software start request |
| start_req | output | 1 | Combined conversion start request |

## Verification
Result words are written with all-ones, single-high-bit, alternating 01 and alternating 10 samples. This shows that each channel has its own storage and that the bit split between the two bytes is correct. Reads in the normal upper-then-lower order are mixed with lower-only reads that address a different channel, and with a converter write placed between the two halves. These three patterns tell live lower-byte data apart from latched data. The trigger is driven with falling and rising edges with the enable cleared, with it set, and after standby clears it. The bench counts the start pulses and checks when they occur.

// File: rtl/adc_rbus_pkg.sv
package adc_rbus_pkg;

   // Kind of byte access selected by an address
   typedef enum logic [1:0] {
      ACC_NONE = 2'd0,
      ACC_HI   = 2'd1,
      ACC_LO   = 2'd2,
      ACC_CTL  = 2'd3
   } acc_kind_t;

endpackage

// File: rtl/adc_rbus_decode.sv
module adc_rbus_decode
   import adc_rbus_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int ADDR_W = 4
) (
   input  logic [ADDR_W-1:0]         addr,
   output acc_kind_t                 kind,
   output logic [$clog2(NUM_CH)-1:0] ch
);
   localparam int CH_W     = $clog2(NUM_CH);
   localparam int RES_SPAN = 2 * NUM_CH;
   localparam int CTL_ADDR = RES_SPAN;

   always_comb begin
      ch = addr[CH_W:1];
      if (int'(addr) < RES_SPAN) begin
         kind = addr[0] ? ACC_LO : ACC_HI;
      end else if (int'(addr) == CTL_ADDR) begin
         kind = ACC_CTL;
      end else begin
         kind = ACC_NONE;
      end
   end
endmodule

// File: rtl/adc_rbus_results.sv
module adc_rbus_results #(
   parameter int NUM_CH   = 4,
   parameter int RES_BITS = 10,
   parameter int BUS_W    = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [$clog2(NUM_CH)-1:0] wr_ch,
   input  logic [RES_BITS-1:0]       wr_val,
   input  logic                      hi_rd,
   input  logic [$clog2(NUM_CH)-1:0] rd_ch,
   output logic [BUS_W-1:0]          hi_byte,
   output logic [BUS_W-1:0]          hold_q
);
   localparam int WORD_W = 2 * BUS_W;
   localparam int PAD_W  = WORD_W - RES_BITS;

   logic [WORD_W-1:0] aligned;
   logic [WORD_W-1:0] word_q [NUM_CH];

   // Left alignment: the variant depends on whether padding is needed
   generate
      if (PAD_W == 0) begin : g_nopad
         assign aligned = wr_val;
      end else begin : g_pad
         assign aligned = {wr_val, {PAD_W{1'b0}}};
      end
   endgenerate

   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_word
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               word_q[i] <= '0;
            end else if (wr_en && (int'(wr_ch) == i)) begin
               word_q[i] <= aligned;
            end
         end
      end
   endgenerate

   assign hi_byte = word_q[rd_ch][WORD_W-1 -: BUS_W];

   // The latch loads only on an upper-byte read
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
      end else if (hi_rd) begin
         hold_q <= word_q[rd_ch][BUS_W-1:0];
      end
   end
endmodule

// File: rtl/adc_rbus_ctl.sv
module adc_rbus_ctl #(
   parameter int BUS_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             standby,
   input  logic             wr_stb,
   input  logic             wr_bit,
   output logic             trig_en,
   output logic [BUS_W-1:0] rd_val
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trig_en <= 1'b0;
      end else if (standby) begin
         trig_en <= 1'b0;
      end else if (wr_stb) begin
         trig_en <= wr_bit;
      end
   end

   assign rd_val = {trig_en, {(BUS_W-1){1'b1}}};
endmodule

// File: rtl/adc_rbus_trig.sv
module adc_rbus_trig #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig_n,
   input  logic enable,
   output logic ext_start
);
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   cur;

   // Synchronizer chain; it resets to the idle (high) level
   generate
      if (SYNC_STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= '1;
            else        sync_q <= trig_n;
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= '1;
            else        sync_q <= {sync_q[SYNC_STAGES-2:0], trig_n};
         end
      end
   endgenerate

   assign cur = sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= cur;
   end

   assign ext_start = enable & prev_q & ~cur;
endmodule

// File: rtl/adc_rbus_bridge.sv
module adc_rbus_bridge
   import adc_rbus_pkg::*;
#(
   parameter int NUM_CH      = 4,
   parameter int RES_BITS    = 10,
   parameter int BUS_W       = 8,
   parameter int ADDR_W      = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      standby,
   input  logic                      bus_sel,
   input  logic                      bus_wr,
   input  logic [ADDR_W-1:0]         bus_addr,
   input  logic [BUS_W-1:0]          bus_wdata,
   output logic [BUS_W-1:0]          bus_rdata,
   input  logic                      cnv_we,
   input  logic [$clog2(NUM_CH)-1:0] cnv_ch,
   input  logic [RES_BITS-1:0]       cnv_data,
   input  logic                      ext_trig_n,
   input  logic                      sw_start,
   output logic                      start_req
);
   localparam int CH_W   = $clog2(NUM_CH);
   localparam int WORD_W = 2 * BUS_W;

   // Parameter checks at elaboration
   generate
      if (RES_BITS <= BUS_W || RES_BITS > WORD_W) begin : g_bad_res
         $error("RES_BITS must exceed BUS_W and fit in two bytes");
      end
      if (NUM_CH < 2 || (1 << CH_W) != NUM_CH) begin : g_bad_ch
         $error("NUM_CH must be a power of two of at least 2");
      end
      if (2 * NUM_CH >= (1 << ADDR_W)) begin : g_bad_addr
         $error("ADDR_W too small for the address map");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
   endgenerate

   acc_kind_t         kind;
   logic [CH_W-1:0]   sel_ch;
   logic [BUS_W-1:0]  hi_byte;
   logic [BUS_W-1:0]  hold_q;
   logic [BUS_W-1:0]  ctl_val;
   logic              trig_en;
   logic              ext_start;
   logic              rd_cyc;
   logic              wr_cyc;

   assign rd_cyc = bus_sel & ~bus_wr;
   assign wr_cyc = bus_sel &  bus_wr;

   adc_rbus_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
      .addr (bus_addr),
      .kind (kind),
      .ch   (sel_ch)
   );

   adc_rbus_results #(.NUM_CH(NUM_CH), .RES_BITS(RES_BITS), .BUS_W(BUS_W)) u_res (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cnv_we),
      .wr_ch   (cnv_ch),
      .wr_val  (cnv_data),
      .hi_rd   (rd_cyc && kind == ACC_HI),
      .rd_ch   (sel_ch),
      .hi_byte (hi_byte),
      .hold_q  (hold_q)
   );

   adc_rbus_ctl #(.BUS_W(BUS_W)) u_ctl (
      .clk     (clk),
      .rst_n   (rst_n),
      .standby (standby),
      .wr_stb  (wr_cyc && kind == ACC_CTL),
      .wr_bit  (bus_wdata[BUS_W-1]),
      .trig_en (trig_en),
      .rd_val  (ctl_val)
   );

   adc_rbus_trig #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
      .clk       (clk),
      .rst_n     (rst_n),
      .trig_n    (ext_trig_n),
      .enable    (trig_en),
      .ext_start (ext_start)
   );

   always_comb begin
      unique case (kind)
         ACC_HI:  bus_rdata = hi_byte;
         ACC_LO:  bus_rdata = hold_q;
         ACC_CTL: bus_rdata = ctl_val;
         default: bus_rdata = '1;
      endcase
   end

   assign start_req = sw_start | ext_start;
endmodule

// File: rtl/adc_rbus_chk.sv
module adc_rbus_chk #(
   parameter int BUS_W  = 8,
   parameter int ADDR_W = 4,
   parameter int NUM_CH = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              standby,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [BUS_W-1:0]  bus_rdata,
   input logic              sw_start,
   input logic              start_req,
   input logic [BUS_W-1:0]  hold_q,
   input logic              trig_en
);
   localparam int CTL_ADDR = 2 * NUM_CH;

   logic hi_read;
   assign hi_read = bus_sel && !bus_wr && (int'(bus_addr) < CTL_ADDR) && !bus_addr[0];

   // R3
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !hi_read |=> $stable(hold_q));

   // R6
   standby_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      standby |=> !trig_en);

   // R7
   trig_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!trig_en && !sw_start) |-> !start_req);

   // R8
   pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_req && !sw_start) |=> !(start_req && !sw_start));

   // R10
   unmapped_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_wr && int'(bus_addr) > CTL_ADDR) |-> bus_rdata == '1);

   // R5
   ctl_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_wr && int'(bus_addr) == CTL_ADDR) |-> bus_rdata[BUS_W-2:0] == '1);

   // R9
   sw_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sw_start |-> start_req);
endmodule

bind adc_rbus_bridge adc_rbus_chk #(.BUS_W(BUS_W), .ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .standby   (standby),
   .bus_sel   (bus_sel),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_rdata (bus_rdata),
   .sw_start  (sw_start),
   .start_req (start_req),
   .hold_q    (hold_q),
   .trig_en   (trig_en)
);

// File: tb/adc_rbus_bridge_test.sv
module adc_rbus_bridge_test;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       standby = 1'b0;
   logic       bus_sel = 1'b0;
   logic       bus_wr = 1'b0;
   logic [3:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       cnv_we = 1'b0;
   logic [1:0] cnv_ch = '0;
   logic [9:0] cnv_data = '0;
   logic       ext_trig_n = 1'b1;
   logic       sw_start = 1'b0;
   logic       start_req;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   adc_rbus_bridge uut (
      .clk(clk), .rst_n(rst_n), .standby(standby),
      .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .cnv_we(cnv_we), .cnv_ch(cnv_ch), .cnv_data(cnv_data),
      .ext_trig_n(ext_trig_n), .sw_start(sw_start), .start_req(start_req)
   );

   task automatic check(string req, int got, int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s got 0x%0h expected 0x%0h", req, got, exp);
      end
   endtask

   task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(posedge clk);
      #1 bus_sel = 1'b0;
   endtask

   task automatic bus_write(input logic [3:0] a, input logic [7:0] v);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
      @(posedge clk);
      #1 bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic cnv_write(input logic [1:0] ch, input logic [9:0] v);
      @(negedge clk);
      cnv_we = 1'b1; cnv_ch = ch; cnv_data = v;
      @(posedge clk);
      #1 cnv_we = 1'b0;
   endtask

   task automatic t_reset();
      logic [7:0] d;
      bus_read(4'd8, d);  check("R5 reset ctl", d, 8'h7F);
      bus_read(4'd3, d);  check("R4 reset latch", d, 8'h00);
      bus_read(4'd6, d);  check("R1 reset result", d, 8'h00);
   endtask

   task automatic t_patterns();
      logic [7:0] d;
      logic [9:0] vals [4] = '{10'h3FF, 10'h201, 10'h155, 10'h2AA};
      for (int i = 0; i < 4; i++) cnv_write(2'(i), vals[i]);
      for (int i = 0; i < 4; i++) begin
         bus_read(4'(2*i), d);   check("R1 upper byte", d, int'(vals[i][9:2]));
         bus_read(4'(2*i+1), d); check("R2 lower byte", d, int'({vals[i][1:0], 6'b0}));
      end
   endtask

   task automatic t_stale();
      logic [7:0] d;
      bus_read(4'd2, d);
      bus_read(4'd7, d);  check("R4 lower-only read is stale", d, 8'h40);
   endtask

   task automatic t_coherent();
      logic [7:0] d;
      bus_read(4'd4, d);  check("R1 ch2 upper", d, 8'h55);
      cnv_write(2'd2, 10'h003);
      bus_read(4'd5, d);  check("R3 latch kept across write", d, 8'h40);
      bus_read(4'd4, d);  check("R3 new upper visible", d, 8'h00);
      bus_read(4'd5, d);  check("R3 new lower after reread", d, 8'hC0);
   endtask

   task automatic t_unmapped();
      logic [7:0] d;
      bus_write(4'd0, 8'h12);
      bus_write(4'd1, 8'h34);
      bus_read(4'd0, d);  check("R10 bus write to result ignored", d, 8'hFF);
      bus_read(4'd1, d);  check("R10 lower unchanged", d, 8'hC0);
      bus_read(4'd9, d);  check("R10 addr 9", d, 8'hFF);
      bus_read(4'd15, d); check("R10 addr 15", d, 8'hFF);
   endtask

   task automatic t_ctl();
      logic [7:0] d;
      bus_write(4'd8, 8'h00);
      bus_read(4'd8, d);  check("R5 write zero", d, 8'h7F);
      bus_write(4'd8, 8'h80);
      bus_read(4'd8, d);  check("R5 enable set", d, 8'hFF);
      @(negedge clk); standby = 1'b1;
      @(negedge clk); standby = 1'b0;
      bus_read(4'd8, d);  check("R6 standby forces reset value", d, 8'h7F);
   endtask

   task automatic count_pulses(input int cycles, output int n);
      n = 0;
      for (int c = 0; c < cycles; c++) begin
         @(negedge clk); #1;
         if (start_req) n++;
      end
   endtask

   task automatic t_trig_off();
      int n;
      bus_write(4'd8, 8'h00);
      @(negedge clk); ext_trig_n = 1'b0;
      count_pulses(6, n);
      @(negedge clk); ext_trig_n = 1'b1;
      count_pulses(6, n);
      check("R7 trigger ignored when disabled", n, 0);
   endtask

   task automatic t_trig_on();
      int n;
      bus_write(4'd8, 8'h80);
      @(negedge clk); ext_trig_n = 1'b0;
      @(negedge clk); #1 check("R8 no pulse after first edge", int'(start_req), 0);
      @(negedge clk); #1 check("R8 pulse after second edge", int'(start_req), 1);
      count_pulses(6, n);
      check("R8 pulse lasts one cycle", n, 0);
      @(negedge clk); ext_trig_n = 1'b1;
      count_pulses(6, n);
      check("R8 rising edge gives no pulse", n, 0);
      @(negedge clk); ext_trig_n = 1'b0;
      count_pulses(8, n);
      check("R8 one pulse per falling edge", n, 1);
      @(negedge clk); ext_trig_n = 1'b1;
      count_pulses(4, n);
   endtask

   task automatic t_sw();
      bus_write(4'd8, 8'h00);
      @(negedge clk); sw_start = 1'b1;
      #1 check("R9 software start passes", int'(start_req), 1);
      @(negedge clk); sw_start = 1'b0;
      #1 check("R9 software start released", int'(start_req), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_patterns();
      t_stale();
      t_coherent();
      t_unmapped();
      t_ctl();
      t_trig_off();
      t_trig_on();
      t_sw();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule